// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block sits between an 8-bit CPU bus with a 16-bit address and the memories and peripherals behind it. On each access it works out which device the address belongs to. It raises that device's select, and its write enable where writes are allowed. It passes on the device-local address and steers the selected read data back to the CPU. The memories and peripheral chips themselves live outside the block.

Three features add state to the otherwise combinational map:
- A swap flag moves the 4 KB boot ROM and the 4 KB RAM page at 0xC000 into each other's place.
- Any read from the 0xE2xx page loads the low address byte into a scroll register. The data bus plays no part in this.
- The disk-interface ROM shows the upper or lower half of its 2 KB according to the level of a DRQ line, sampled on every access.

Accesses are single-cycle. Selects, enables and read data follow the inputs combinationally. The swap and scroll registers change on the clock edge that carries the qualifying strobe. Read and write strobes are assumed never to be high together.

Top module: `mem_map_dec`

## Requirements
- R1: With swap clear, a read in 0x0000–0x0FFF asserts rom_cs_o with rom_addr_o = addr[11:0] and returns the boot ROM byte. A write there asserts no select and no write enable. Accesses in 0xC000–0xCFFF go to RAM at the same address.
- R2: With swap set, accesses in 0x0000–0x0FFF go to RAM with ram_addr_o = 0xC000 | addr[11:0]. Reads in 0xC000–0xCFFF return the boot ROM byte at addr[11:0]. Writes in 0xC000–0xCFFF assert no select and no write enable.
- R3: swap_o resets to 0. It becomes 1 after a clock edge with swap_set_i high. It becomes 0 after an edge with only swap_clr_i high. When both inputs are high, set wins.
- R4: 0x1000–0xBFFF is RAM. ram_cs_o is high on a read or a write, ram_we_o is high on a write, and ram_addr_o equals addr_i. During any write, mem_wdata_o carries wdata_i; otherwise it is 0.
- R5: 0xD000–0xD7FF selects video RAM with vram_addr_o = addr[10:0]. A read in 0xD800–0xDFFF returns 0xFF, and no access in that range asserts any select or enable.
- R6: 0xE000–0xE003 selects the parallel port and 0xE004–0xE007 the timer. io_reg_o = addr[1:0], io_wr_o is high on writes, and a read returns the selected chip's data.
- R7: A read of 0xE008 returns {hblank_i, 6'b111111, tempo_i}.
- R8: scroll_o resets to 0. A read in 0xE200–0xE2FF loads addr[7:0] on that clock edge. Writes to that page and reads elsewhere leave it unchanged.
- R9: A read in 0xE800–0xEFFF asserts ext_cs_o with ext_addr_o = addr[10:0]. A write there asserts no select.
- R10: A read in 0xF000–0xF7FF asserts dif_cs_o with dif_addr_o = {drq_i, addr[9:0]}. As a result, 0xF400–0xF7FF mirrors 0xF000–0xF3FF.
- R11: Reads of 0xF800–0xFFFF return 0xFF with no select asserted.
- R12: At most one select output is high at any time. No select is high and rdata_o is 0x00 while neither strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data to CPU |
| swap_set_i | input | 1 | Set the swap flag |
| swap_clr_i | input | 1 | Clear the swap flag |
| drq_i | input | 1 | Disk DRQ; picks the disk ROM half |
| hblank_i | input | 1 | Horizontal blank status bit |
| tempo_i | input | 1 | Tempo status bit |
| mem_wdata_o | output | 8 | Write data to devices |
| rom_cs_o | output | 1 | Boot ROM select |
| rom_addr_o | output | 12 | Boot ROM address |
| rom_rdata_i | input | 8 | Boot ROM data |
| ram_cs_o | output | 1 | Main RAM select |
| ram_we_o | output | 1 | Main RAM write enable |
| ram_addr_o | output | 16 | Main RAM address |
| ram_rdata_i | input | 8 | Main RAM data |
| vram_cs_o | output | 1 | Video RAM select |
| vram_we_o | output | 1 | Video RAM write enable |
| vram_addr_o | output | 11 | Video RAM address |
| vram_rdata_i | input | 8 | Video RAM data |
| pio_cs_o | output | 1 | Parallel port select |
| tmr_cs_o | output | 1 | Timer select |
| io_wr_o | output | 1 | Peripheral write |
| io_reg_o | output | 2 | Peripheral register index |
| pio_rdata_i | input | 8 | Parallel port data |
| tmr_rdata_i | input | 8 | Timer data |
| ext_cs_o | output | 1 | Extension ROM select |
| ext_addr_o | output | 11 | Extension ROM address |
| ext_rdata_i | input | 8 | Extension ROM data |
| dif_cs_o | output | 1 | Disk ROM select |
| dif_addr_o | output | 11 | Disk ROM address |
| dif_rdata_i | input | 8 | Disk ROM data |
| swap_o | output | 1 | Swap flag |
| scroll_o | output | 8 | Scroll register |

## Verification
The bench writes to the boot ROM page with swap clear and to 0xCxxx with swap set. A decoder that let those writes through would raise a RAM write enable and corrupt the page hidden behind the ROM. It reads the 0xE2xx page and then writes to it. A design that loaded the scroll register from data, or on writes, would show the wrong scroll_o value. It reads the disk ROM with DRQ low and then with DRQ high in the mirror window, which exposes a half-select taken from an address bit or a mirror that was not folded. It also probes the unmapped holes at 0xD800 and 0xF800 and drives set and clear together. These catch stray selects, data other than 0xFF, and the wrong precedence on the swap flag.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  typedef enum logic [3:0] {
    RG_NONE, RG_ROM, RG_RAM, RG_VRAM, RG_PIO, RG_TMR, RG_STAT, RG_EXT, RG_DIF
  } region_e;

  localparam logic [11:0] STAT_OFS = 12'h008;
  localparam logic [7:0]  SCROLL_PAGE = 8'hE2;
endpackage

// File: rtl/mmd_decode.sv
module mmd_decode
  import mmd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic          swap_i,
  output region_e       region_o,
  output logic          scroll_win_o
);
  logic [3:0]  blk;
  logic [11:0] ofs;
  assign blk = addr_i[AW-1 -: 4];
  assign ofs = addr_i[11:0];

  always_comb begin
    region_o = RG_NONE;
    unique case (blk)
      4'h0: region_o = swap_i ? RG_RAM : RG_ROM;
      4'hC: region_o = swap_i ? RG_ROM : RG_RAM;
      4'hD: region_o = ofs[11] ? RG_NONE : RG_VRAM;
      4'hE: begin
        if (ofs[11])                region_o = RG_EXT;
        else if (ofs[10:3] == '0)   region_o = ofs[2] ? RG_TMR : RG_PIO;
        else if (ofs == STAT_OFS)   region_o = RG_STAT;
        else                        region_o = RG_NONE;
      end
      4'hF: region_o = ofs[11] ? RG_NONE : RG_DIF;
      default: region_o = RG_RAM;
    endcase
  end

  assign scroll_win_o = (addr_i[AW-1 -: 8] == SCROLL_PAGE);
endmodule

// File: rtl/mmd_regs.sv
module mmd_regs #(
  parameter int SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          swap_set_i,
  input  logic          swap_clr_i,
  input  logic          rd_i,
  input  logic          scroll_win_i,
  input  logic [SW-1:0] addr_lo_i,
  output logic          swap_o,
  output logic [SW-1:0] scroll_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          swap_o <= 1'b0;
    else if (swap_set_i)  swap_o <= 1'b1;
    else if (swap_clr_i)  swap_o <= 1'b0;
  end

  // scroll offset comes from the address of the read, not the data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   scroll_o <= '0;
    else if (rd_i && scroll_win_i) scroll_o <= addr_lo_i;
  end
endmodule

// File: rtl/mmd_rmux.sv
module mmd_rmux
  import mmd_pkg::*;
#(
  parameter int          DW   = 8,
  parameter logic [DW-1:0] FILL = '1
) (
  input  region_e       region_i,
  input  logic          rd_i,
  input  logic          hblank_i,
  input  logic          tempo_i,
  input  logic [DW-1:0] rom_i,
  input  logic [DW-1:0] ram_i,
  input  logic [DW-1:0] vram_i,
  input  logic [DW-1:0] pio_i,
  input  logic [DW-1:0] tmr_i,
  input  logic [DW-1:0] ext_i,
  input  logic [DW-1:0] dif_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] stat;
  assign stat = {hblank_i, {(DW-2){1'b1}}, tempo_i};

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (region_i)
        RG_ROM:  rdata_o = rom_i;
        RG_RAM:  rdata_o = ram_i;
        RG_VRAM: rdata_o = vram_i;
        RG_PIO:  rdata_o = pio_i;
        RG_TMR:  rdata_o = tmr_i;
        RG_STAT: rdata_o = stat;
        RG_EXT:  rdata_o = ext_i;
        RG_DIF:  rdata_o = dif_i;
        default: rdata_o = FILL;
      endcase
    end
  end
endmodule

// File: rtl/mem_map_dec.sv
module mem_map_dec
  import mmd_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int ROM_AW  = 12,
  parameter int VRAM_AW = 11,
  parameter int EXT_AW  = 11,
  parameter int DIF_AW  = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               rd_i,
  input  logic               wr_i,
  output logic [DW-1:0]      rdata_o,
  input  logic               swap_set_i,
  input  logic               swap_clr_i,
  input  logic               drq_i,
  input  logic               hblank_i,
  input  logic               tempo_i,
  output logic [DW-1:0]      mem_wdata_o,
  output logic               rom_cs_o,
  output logic [ROM_AW-1:0]  rom_addr_o,
  input  logic [DW-1:0]      rom_rdata_i,
  output logic               ram_cs_o,
  output logic               ram_we_o,
  output logic [AW-1:0]      ram_addr_o,
  input  logic [DW-1:0]      ram_rdata_i,
  output logic               vram_cs_o,
  output logic               vram_we_o,
  output logic [VRAM_AW-1:0] vram_addr_o,
  input  logic [DW-1:0]      vram_rdata_i,
  output logic               pio_cs_o,
  output logic               tmr_cs_o,
  output logic               io_wr_o,
  output logic [1:0]         io_reg_o,
  input  logic [DW-1:0]      pio_rdata_i,
  input  logic [DW-1:0]      tmr_rdata_i,
  output logic               ext_cs_o,
  output logic [EXT_AW-1:0]  ext_addr_o,
  input  logic [DW-1:0]      ext_rdata_i,
  output logic               dif_cs_o,
  output logic [DIF_AW-1:0]  dif_addr_o,
  input  logic [DW-1:0]      dif_rdata_i,
  output logic               swap_o,
  output logic [7:0]         scroll_o
);
  localparam int DIF_WIN = DIF_AW - 1;
  localparam logic [3:0] HI_PAGE = 4'hC;

  region_e region;
  logic    scroll_win;
  logic    acc;

  mmd_decode #(.AW(AW)) u_dec (
    .addr_i       (addr_i),
    .swap_i       (swap_o),
    .region_o     (region),
    .scroll_win_o (scroll_win)
  );

  mmd_regs #(.SW(8)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .swap_set_i   (swap_set_i),
    .swap_clr_i   (swap_clr_i),
    .rd_i         (rd_i),
    .scroll_win_i (scroll_win),
    .addr_lo_i    (addr_i[7:0]),
    .swap_o       (swap_o),
    .scroll_o     (scroll_o)
  );

  mmd_rmux #(.DW(DW)) u_rmux (
    .region_i (region),
    .rd_i     (rd_i),
    .hblank_i (hblank_i),
    .tempo_i  (tempo_i),
    .rom_i    (rom_rdata_i),
    .ram_i    (ram_rdata_i),
    .vram_i   (vram_rdata_i),
    .pio_i    (pio_rdata_i),
    .tmr_i    (tmr_rdata_i),
    .ext_i    (ext_rdata_i),
    .dif_i    (dif_rdata_i),
    .rdata_o  (rdata_o)
  );

  assign acc = rd_i | wr_i;

  // read-only regions select on reads only; writes there vanish
  assign rom_cs_o  = rd_i && region == RG_ROM;
  assign ext_cs_o  = rd_i && region == RG_EXT;
  assign dif_cs_o  = rd_i && region == RG_DIF;

  assign ram_cs_o  = acc  && region == RG_RAM;
  assign ram_we_o  = wr_i && region == RG_RAM;
  assign vram_cs_o = acc  && region == RG_VRAM;
  assign vram_we_o = wr_i && region == RG_VRAM;
  assign pio_cs_o  = acc  && region == RG_PIO;
  assign tmr_cs_o  = acc  && region == RG_TMR;
  assign io_wr_o   = wr_i && (region == RG_PIO || region == RG_TMR);
  assign io_reg_o  = addr_i[1:0];

  assign mem_wdata_o = wr_i ? wdata_i : '0;

  assign rom_addr_o  = addr_i[ROM_AW-1:0];
  assign ram_addr_o  = (addr_i[AW-1 -: 4] == 4'h0) ?
                       {HI_PAGE, addr_i[AW-5:0]} : addr_i;
  assign vram_addr_o = addr_i[VRAM_AW-1:0];
  assign ext_addr_o  = addr_i[EXT_AW-1:0];
  assign dif_addr_o  = {drq_i, addr_i[DIF_WIN-1:0]};
endmodule

// File: rtl/mmd_checker.sv
module mmd_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic        rd_i,
  input logic        wr_i,
  input logic        swap_set_i,
  input logic        swap_clr_i,
  input logic        drq_i,
  input logic        rom_cs_o,
  input logic        ram_cs_o,
  input logic        ram_we_o,
  input logic [15:0] ram_addr_o,
  input logic        vram_cs_o,
  input logic        pio_cs_o,
  input logic        tmr_cs_o,
  input logic        ext_cs_o,
  input logic        dif_cs_o,
  input logic [10:0] dif_addr_o,
  input logic        swap_o,
  input logic [7:0]  scroll_o
);
  logic [6:0] sels;
  assign sels = {rom_cs_o, ram_cs_o, vram_cs_o, pio_cs_o, tmr_cs_o, ext_cs_o, dif_cs_o};

  a_r1_rom_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15:12] == 4'h0 && !swap_o) |-> (!rom_cs_o && !ram_we_o));

  a_r2_low_page_to_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[15:12] == 4'h0 && swap_o) |-> (ram_cs_o && ram_addr_o[15:12] == 4'hC));

  a_r3_swap_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_set_i |=> swap_o);

  a_r3_swap_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_clr_i && !swap_set_i) |=> !swap_o);

  a_r8_scroll_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[15:8] == 8'hE2) |=> (scroll_o == $past(addr_i[7:0])));

  a_r8_scroll_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && addr_i[15:8] == 8'hE2) |=> $stable(scroll_o));

  a_r10_dif_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dif_cs_o |-> (dif_addr_o[10] == drq_i));

  a_r12_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sels));

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i) |-> (sels == '0));
endmodule

bind mem_map_dec mmd_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .swap_set_i (swap_set_i),
  .swap_clr_i (swap_clr_i),
  .drq_i      (drq_i),
  .rom_cs_o   (rom_cs_o),
  .ram_cs_o   (ram_cs_o),
  .ram_we_o   (ram_we_o),
  .ram_addr_o (ram_addr_o),
  .vram_cs_o  (vram_cs_o),
  .pio_cs_o   (pio_cs_o),
  .tmr_cs_o   (tmr_cs_o),
  .ext_cs_o   (ext_cs_o),
  .dif_cs_o   (dif_cs_o),
  .dif_addr_o (dif_addr_o),
  .swap_o     (swap_o),
  .scroll_o   (scroll_o)
);

// File: tb/sim_mem_map_dec.sv
module sim_mem_map_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic        sset = 1'b0, sclr = 1'b0, drq = 1'b0, hbl = 1'b0, tmp = 1'b0;
  logic [7:0]  rdata, mwd;
  logic        rom_cs, ram_cs, ram_we, vram_cs, vram_we, pio_cs, tmr_cs, io_wr;
  logic        ext_cs, dif_cs, swap;
  logic [11:0] rom_a;
  logic [15:0] ram_a;
  logic [10:0] vram_a, ext_a, dif_a;
  logic [1:0]  io_reg;
  logic [7:0]  scroll;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  // device models: each returns a distinct function of its own address
  function automatic logic [7:0] f_rom(input logic [11:0] a);  return a[7:0] ^ {4'h5, a[11:8]}; endfunction
  function automatic logic [7:0] f_ram(input logic [15:0] a);  return a[15:8] + a[7:0]; endfunction
  function automatic logic [7:0] f_vram(input logic [10:0] a); return ~a[7:0] ^ {5'd0, a[10:8]}; endfunction
  function automatic logic [7:0] f_ext(input logic [10:0] a);  return a[7:0] ^ 8'h3C ^ {5'd0, a[10:8]}; endfunction
  function automatic logic [7:0] f_dif(input logic [10:0] a);  return a[7:0] + {a[10:8], 5'd7}; endfunction
  function automatic logic [7:0] f_pio(input logic [1:0] r);   return 8'h90 | {6'd0, r}; endfunction
  function automatic logic [7:0] f_tmr(input logic [1:0] r);   return 8'h40 | {6'd0, r}; endfunction

  mem_map_dec u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .rd_i(rd), .wr_i(wr),
    .rdata_o(rdata), .swap_set_i(sset), .swap_clr_i(sclr), .drq_i(drq),
    .hblank_i(hbl), .tempo_i(tmp), .mem_wdata_o(mwd),
    .rom_cs_o(rom_cs), .rom_addr_o(rom_a), .rom_rdata_i(f_rom(rom_a)),
    .ram_cs_o(ram_cs), .ram_we_o(ram_we), .ram_addr_o(ram_a), .ram_rdata_i(f_ram(ram_a)),
    .vram_cs_o(vram_cs), .vram_we_o(vram_we), .vram_addr_o(vram_a), .vram_rdata_i(f_vram(vram_a)),
    .pio_cs_o(pio_cs), .tmr_cs_o(tmr_cs), .io_wr_o(io_wr), .io_reg_o(io_reg),
    .pio_rdata_i(f_pio(io_reg)), .tmr_rdata_i(f_tmr(io_reg)),
    .ext_cs_o(ext_cs), .ext_addr_o(ext_a), .ext_rdata_i(f_ext(ext_a)),
    .dif_cs_o(dif_cs), .dif_addr_o(dif_a), .dif_rdata_i(f_dif(dif_a)),
    .swap_o(swap), .scroll_o(scroll)
  );

  function automatic int sel_cnt();
    return int'(rom_cs) + int'(ram_cs) + int'(vram_cs) + int'(pio_cs) +
           int'(tmr_cs) + int'(ext_cs) + int'(dif_cs);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic go_rd(input logic [15:0] a);
    @(negedge clk); addr = a; rd = 1'b1; wr = 1'b0; #1;
  endtask
  task automatic go_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1; rd = 1'b0; #1;
  endtask
  task automatic idle();
    @(negedge clk); rd = 1'b0; wr = 1'b0; addr = 16'h1000; #1;
  endtask

  task automatic t_reset();
    chk("R3 swap reset", swap, 0);
    chk("R8 scroll reset", scroll, 0);
    chk("R12 idle rdata", rdata, 0);
    chk("R12 idle selects", sel_cnt(), 0);
  endtask

  task automatic t_boot();
    go_rd(16'h0123);
    chk("R1 rom cs", rom_cs, 1);
    chk("R1 rom data", rdata, f_rom(12'h123));
    go_wr(16'h0040, 8'h77);
    chk("R1 write dropped", {rom_cs, ram_cs, ram_we}, 0);
    go_rd(16'hC456);
    chk("R1 high page ram", {ram_cs, ram_a}, {1'b1, 16'hC456});
    chk("R1 high page data", rdata, f_ram(16'hC456));
    idle();
  endtask

  task automatic t_swap();
    @(negedge clk); sset = 1'b1;
    @(negedge clk); sset = 1'b0; #1;
    chk("R3 set", swap, 1);
    go_rd(16'h0456);
    chk("R2 low page ram addr", {ram_cs, ram_a}, {1'b1, 16'hC456});
    chk("R2 low page data", rdata, f_ram(16'hC456));
    go_rd(16'hC010);
    chk("R2 rom at C", {rom_cs, rom_a}, {1'b1, 12'h010});
    chk("R2 rom data at C", rdata, f_rom(12'h010));
    go_wr(16'hC010, 8'h11);
    chk("R2 write at C dropped", {rom_cs, ram_cs, ram_we}, 0);
    idle();
    @(negedge clk); sset = 1'b1; sclr = 1'b1;
    @(negedge clk); sset = 1'b0; #1;
    chk("R3 set beats clear", swap, 1);
    @(negedge clk); sclr = 1'b0; #1;
    chk("R3 clear", swap, 0);
  endtask

  task automatic t_ram();
    go_wr(16'h1234, 8'hA6);
    chk("R4 write", {ram_cs, ram_we, ram_a}, {2'b11, 16'h1234});
    chk("R4 wdata", mwd, 8'hA6);
    go_rd(16'hBFFF);
    chk("R4 read", {ram_cs, ram_we, rdata}, {2'b10, f_ram(16'hBFFF)});
    chk("R4 wdata quiet", mwd, 0);
    idle();
  endtask

  task automatic t_vram();
    go_rd(16'hD7FF);
    chk("R5 vram read", {vram_cs, vram_a, rdata}, {1'b1, 11'h7FF, f_vram(11'h7FF)});
    go_wr(16'hD123, 8'h42);
    chk("R5 vram write", {vram_cs, vram_we}, 2'b11);
    go_rd(16'hD800);
    chk("R5 hole read", {sel_cnt(), rdata}, {32'd0, 8'hFF});
    go_wr(16'hDFFF, 8'h00);
    chk("R5 hole write", {sel_cnt(), vram_we, ram_we}, 34'd0);
    idle();
  endtask

  task automatic t_io();
    go_rd(16'hE002);
    chk("R6 pio read", {pio_cs, io_reg, rdata}, {1'b1, 2'd2, f_pio(2'd2)});
    go_wr(16'hE005, 8'h5A);
    chk("R6 timer write", {tmr_cs, io_wr, io_reg, pio_cs}, {2'b11, 2'd1, 1'b0});
    go_rd(16'hE007);
    chk("R6 timer read", rdata, f_tmr(2'd3));
    idle();
  endtask

  task automatic t_status();
    hbl = 1'b1; tmp = 1'b0;
    go_rd(16'hE008);
    chk("R7 status hblank", rdata, 8'hFE);
    hbl = 1'b0; tmp = 1'b1; #1;
    chk("R7 status tempo", rdata, 8'h7F);
    idle();
  endtask

  task automatic t_scroll();
    go_rd(16'hE2A7);
    @(negedge clk); rd = 1'b0; #1;
    chk("R8 load from address", scroll, 8'hA7);
    go_wr(16'hE255, 8'h33);
    @(negedge clk); wr = 1'b0; #1;
    chk("R8 write ignored", scroll, 8'hA7);
    go_rd(16'hE1FF);
    @(negedge clk); rd = 1'b0; #1;
    chk("R8 other read ignored", scroll, 8'hA7);
    idle();
  endtask

  task automatic t_ext();
    go_rd(16'hE9AB);
    chk("R9 ext read", {ext_cs, ext_a, rdata}, {1'b1, 11'h1AB, f_ext(11'h1AB)});
    go_wr(16'hE9AB, 8'h01);
    chk("R9 ext write dropped", sel_cnt(), 0);
    idle();
  endtask

  task automatic t_dif();
    drq = 1'b0;
    go_rd(16'hF123);
    chk("R10 low half", {dif_cs, dif_a, rdata}, {1'b1, 11'h123, f_dif(11'h123)});
    drq = 1'b1;
    go_rd(16'hF523);
    chk("R10 mirror upper half", {dif_cs, dif_a, rdata}, {1'b1, 11'h523, f_dif(11'h523)});
    drq = 1'b0; #1;
    chk("R10 live drq", dif_a, 11'h123);
    idle();
  endtask

  task automatic t_top();
    go_rd(16'hF800);
    chk("R11 F800", {sel_cnt(), rdata}, {32'd0, 8'hFF});
    go_rd(16'hFFFF);
    chk("R11 FFFF", {sel_cnt(), rdata}, {32'd0, 8'hFF});
    idle();
    chk("R12 idle after reads", {sel_cnt(), rdata}, 40'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    #20 rst_n = 1'b1;
    t_boot();
    t_swap();
    t_ram();
    t_vram();
    t_io();
    t_status();
    t_scroll();
    t_ext();
    t_dif();
    t_top();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule